// File: doc/BRIEF.md
# Multi-lane variable-length bit packer

This block accepts up to four variable-length code words in one clock cycle and joins them into one continuous bitstream, which it cuts into fixed 32-bit output blocks. Each lane has its own word and a bit-length field. Bits that do not fill a whole block are carried into the next accepted cycle. The words are never shifted in one at a time. A first stage takes a prefix sum over the lane lengths. A second stage adds the carried bit count, which gives each word an absolute bit offset and gives the cycle a count of blocks. A third stage places every word at its offset and extracts the finished blocks.

Each cycle's finished blocks go into an entry FIFO as one group. A group holds at most six blocks, together with its block count and an end-of-stream flag. The output side drains the FIFO one block per valid/ready transfer. The input ready signal drops early enough that every group still inside the pipeline can be stored. An end-of-stream flag given with an input cycle flushes the stream: the partial block is emitted and the carry is cleared.

Top module: `varlen_packer`

## Requirements
- R1: Within an accepted cycle, lanes are taken in order 0, 1, 2, 3. Of each word, the low `len` bits are appended, most significant bit first, directly after the bits already pending. Each output block is filled from bit 31 down to bit 0.
- R2: Word bits at or above the lane's length have no effect on the stream. A lane of length 0 adds nothing.
- R3: Bits that do not complete a block are kept, in order, across accepted cycles until later words complete the block. Fewer than 32 such bits are ever pending.
- R4: When `in_last` is high on an accepted cycle and bits remain pending after that cycle's words, those bits go out as one extra block. It is zero-padded in its low bits, carries `out_last` = 1, and the pending count returns to zero.
- R5: When `in_last` is high and no bits remain pending, `out_last` is set on the last full block of that cycle. If that cycle completes no block, one all-zero block with `out_last` = 1 is emitted.
- R6: While `out_valid` is high and `out_ready` is low, `out_block` and `out_last` hold their values. Each transfer with both high delivers exactly one block, in stream order, with none lost or repeated.
- R7: `in_ready` is high only while the FIFO holds fewer than DEPTH−3 groups. Starting empty, with the output stalled and every accepted cycle making one group, exactly DEPTH cycles are accepted. No block is lost.
- R8: After reset, `out_valid` is 0, `in_ready` is 1 and no bits are pending.
- R9: Cycles with `in_valid` low add nothing to the stream, whatever the word, length and last inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input cycle offered |
| in_ready | output | 1 | Packer accepts the offered cycle |
| in_word | input | LANES*WORD_W | Lane words, lane k in bits [k*WORD_W +: WORD_W], right aligned |
| in_len | input | LANES*LEN_W | Lane bit lengths 0..WORD_W, lane k in bits [k*LEN_W +: LEN_W] |
| in_last | input | 1 | Flush the stream after this cycle's words |
| out_valid | output | 1 | A block is available |
| out_ready | input | 1 | Consumer takes the block |
| out_block | output | BLK_W | Packed block, first bit in the MSB |
| out_last | output | 1 | Final block of a flushed stream |

## Verification
The assertions assume that every lane length offered with `in_valid` is at most WORD_W. They also assume that `in_last` is read only on accepted cycles. The stimulus draws lengths from 0 to 32 only and fills the word bits above each length with random values. The bench drives the output handshake freely, since the block must hold its data on its own while stalled. The long random phase offers far more bits than the drain rate can take, so the ready threshold is under constant load while the stream is compared block by block.

// File: rtl/vlp_pkg.sv
package vlp_pkg;

  // Blocks leaving the packer for one accepted cycle.
  function automatic int blocks_out(int total_bits, int blk_w, bit flush);
    int full_n;
    int tail;
    full_n = total_bits / blk_w;
    tail   = total_bits % blk_w;
    if (!flush) return full_n;
    if (tail != 0 || full_n == 0) return full_n + 1;
    return full_n;
  endfunction

  // Pending bit count after one accepted cycle.
  function automatic int carry_out(int total_bits, int blk_w, bit flush);
    return flush ? 0 : total_bits % blk_w;
  endfunction

  // Left shift that puts a right-aligned word of length len at bit offset pos
  // (counted from the chain MSB).
  function automatic int lane_shift(int chain_w, int pos, int len);
    return chain_w - pos - len;
  endfunction

endpackage

// File: rtl/vlp_prefix.sv
module vlp_prefix #(
  parameter int LANES  = 4,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 6,
  parameter int SUM_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take_i,
  input  logic [LANES*WORD_W-1:0] word_i,
  input  logic [LANES*LEN_W-1:0]  len_i,
  input  logic                    last_i,
  output logic                    v_o,
  output logic [LANES*WORD_W-1:0] word_o,
  output logic [LANES*LEN_W-1:0]  len_o,
  output logic [LANES*SUM_W-1:0]  pre_o,
  output logic [SUM_W-1:0]        tot_o,
  output logic                    last_o
);
  localparam logic [WORD_W-1:0] ONE_W = WORD_W'(1);

  logic [LANES*WORD_W-1:0] masked;
  logic [LANES*SUM_W-1:0]  pre_n;
  logic [SUM_W-1:0]        run;

  // Clear every bit at or above the lane length.
  for (genvar g = 0; g < LANES; g++) begin : g_mask
    logic [LEN_W-1:0]  len_g;
    logic [WORD_W:0]   one_sh;
    assign len_g  = len_i[g*LEN_W +: LEN_W];
    assign one_sh = {{WORD_W{1'b0}}, 1'b1} << len_g;
    assign masked[g*WORD_W +: WORD_W] =
      word_i[g*WORD_W +: WORD_W] & (one_sh[WORD_W-1:0] - ONE_W);
  end

  // Exclusive prefix sum of the lane lengths.
  always_comb begin
    run   = '0;
    pre_n = '0;
    for (int i = 0; i < LANES; i++) begin
      pre_n[i*SUM_W +: SUM_W] = run;
      run = run + SUM_W'(len_i[i*LEN_W +: LEN_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o    <= 1'b0;
      word_o <= '0;
      len_o  <= '0;
      pre_o  <= '0;
      tot_o  <= '0;
      last_o <= 1'b0;
    end else begin
      v_o <= take_i;
      if (take_i) begin
        word_o <= masked;
        len_o  <= len_i;
        pre_o  <= pre_n;
        tot_o  <= run;
        last_o <= last_i;
      end
    end
  end

endmodule

// File: rtl/vlp_offset.sv
module vlp_offset #(
  parameter int LANES  = 4,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 6,
  parameter int SUM_W  = 8,
  parameter int BLK_W  = 32,
  parameter int CNT_W  = 3,
  parameter int CAR_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    v_i,
  input  logic [LANES*WORD_W-1:0] word_i,
  input  logic [LANES*LEN_W-1:0]  len_i,
  input  logic [LANES*SUM_W-1:0]  pre_i,
  input  logic [SUM_W-1:0]        tot_i,
  input  logic                    last_i,
  output logic                    v_o,
  output logic [LANES*WORD_W-1:0] word_o,
  output logic [LANES*LEN_W-1:0]  len_o,
  output logic [LANES*SUM_W-1:0]  pos_o,
  output logic [CNT_W-1:0]        nfull_o,
  output logic [CNT_W-1:0]        cnt_o,
  output logic                    last_o,
  output logic [CAR_W-1:0]        carry_len_o
);
  logic [CAR_W-1:0]       carry_q;
  logic [SUM_W-1:0]       total;
  logic [LANES*SUM_W-1:0] pos_n;
  logic [CNT_W-1:0]       cnt_n;
  logic [CNT_W-1:0]       nfull_n;
  logic [CAR_W-1:0]       carry_n;

  always_comb begin
    total   = SUM_W'(carry_q) + tot_i;
    cnt_n   = CNT_W'(vlp_pkg::blocks_out(int'(total), BLK_W, last_i));
    nfull_n = CNT_W'(int'(total) / BLK_W);
    carry_n = CAR_W'(vlp_pkg::carry_out(int'(total), BLK_W, last_i));
    for (int i = 0; i < LANES; i++)
      pos_n[i*SUM_W +: SUM_W] = pre_i[i*SUM_W +: SUM_W] + SUM_W'(carry_q);
  end

  assign carry_len_o = carry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o     <= 1'b0;
      carry_q <= '0;
      word_o  <= '0;
      len_o   <= '0;
      pos_o   <= '0;
      nfull_o <= '0;
      cnt_o   <= '0;
      last_o  <= 1'b0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        carry_q <= carry_n;
        word_o  <= word_i;
        len_o   <= len_i;
        pos_o   <= pos_n;
        nfull_o <= nfull_n;
        cnt_o   <= cnt_n;
        last_o  <= last_i;
      end
    end
  end

endmodule

// File: rtl/vlp_combine.sv
module vlp_combine #(
  parameter int LANES  = 4,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 6,
  parameter int SUM_W  = 8,
  parameter int BLK_W  = 32,
  parameter int NMAX   = 6,
  parameter int CNT_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    v_i,
  input  logic [LANES*WORD_W-1:0] word_i,
  input  logic [LANES*LEN_W-1:0]  len_i,
  input  logic [LANES*SUM_W-1:0]  pos_i,
  input  logic [CNT_W-1:0]        nfull_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    last_i,
  output logic                    v_o,
  output logic [NMAX*BLK_W-1:0]   chain_o,
  output logic [CNT_W-1:0]        cnt_o,
  output logic                    last_o
);
  localparam int CHAIN_W = NMAX * BLK_W;

  logic [BLK_W-1:0]   rem_q;
  logic [CHAIN_W-1:0] chain;
  logic [CHAIN_W-1:0] chain_adv;
  logic [BLK_W-1:0]   rem_n;

  // Pending bits sit at the chain MSB; each word lands at its own offset.
  always_comb begin
    chain = '0;
    chain[CHAIN_W-1 -: BLK_W] = rem_q;
    for (int i = 0; i < LANES; i++) begin
      chain = chain | (CHAIN_W'(word_i[i*WORD_W +: WORD_W])
                       << vlp_pkg::lane_shift(CHAIN_W,
                                              int'(pos_i[i*SUM_W +: SUM_W]),
                                              int'(len_i[i*LEN_W +: LEN_W])));
    end
    chain_adv = chain << (int'(nfull_i) * BLK_W);
    rem_n     = chain_adv[CHAIN_W-1 -: BLK_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      v_o     <= 1'b0;
      chain_o <= '0;
      cnt_o   <= '0;
      last_o  <= 1'b0;
    end else begin
      v_o <= v_i && (cnt_i != '0);
      if (v_i) begin
        rem_q   <= last_i ? '0 : rem_n;
        chain_o <= chain;
        cnt_o   <= cnt_i;
        last_o  <= last_i;
      end
    end
  end

endmodule

// File: rtl/vlp_outq.sv
module vlp_outq #(
  parameter int BLK_W = 32,
  parameter int NMAX  = 6,
  parameter int CNT_W = 3,
  parameter int DEPTH = 8,
  parameter int OCC_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_i,
  input  logic [NMAX*BLK_W-1:0] chain_i,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic                  last_i,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [BLK_W-1:0]      out_block,
  output logic                  out_last,
  output logic [OCC_W-1:0]      occ_o,
  output logic                  full_o
);
  localparam int CHAIN_W = NMAX * BLK_W;
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CHAIN_W-1:0] mem_chain [DEPTH];
  logic [CNT_W-1:0]   mem_cnt   [DEPTH];
  logic               mem_last  [DEPTH];

  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [OCC_W-1:0]   occ_q;
  logic [CNT_W-1:0]   idx_q;
  logic [CHAIN_W-1:0] head_sh;
  logic               do_push, beat, last_beat, pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full_o    = (occ_q == OCC_W'(DEPTH));
  assign occ_o     = occ_q;
  assign do_push   = push_i && !full_o;
  assign out_valid = (occ_q != '0);
  assign head_sh   = mem_chain[rd_ptr] << (int'(idx_q) * BLK_W);
  assign out_block = head_sh[CHAIN_W-1 -: BLK_W];
  assign last_beat = (idx_q == mem_cnt[rd_ptr] - CNT_W'(1));
  assign out_last  = mem_last[rd_ptr] && last_beat;
  assign beat      = out_valid && out_ready;
  assign pop       = beat && last_beat;

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_chain[wr_ptr] <= chain_i;
      mem_cnt[wr_ptr]   <= cnt_i;
      mem_last[wr_ptr]  <= last_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
      idx_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (pop)     rd_ptr <= nxt(rd_ptr);
      if (beat)    idx_q  <= last_beat ? '0 : idx_q + CNT_W'(1);
      case ({do_push, pop})
        2'b10:   occ_q <= occ_q + OCC_W'(1);
        2'b01:   occ_q <= occ_q - OCC_W'(1);
        default: occ_q <= occ_q;
      endcase
    end
  end

endmodule

// File: rtl/varlen_packer.sv
module varlen_packer #(
  parameter int LANES  = 4,
  parameter int WORD_W = 32,
  parameter int BLK_W  = 32,
  parameter int DEPTH  = 8,
  parameter int LEN_W  = $clog2(WORD_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*WORD_W-1:0] in_word,
  input  logic [LANES*LEN_W-1:0]  in_len,
  input  logic                    in_last,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [BLK_W-1:0]        out_block,
  output logic                    out_last
);
  localparam int STAGES  = 3;
  localparam int MAXBITS = BLK_W - 1 + LANES * WORD_W;
  localparam int SUM_W   = $clog2(MAXBITS + 1);
  localparam int NMAX    = (MAXBITS + BLK_W - 1) / BLK_W + 1;
  localparam int CNT_W   = $clog2(NMAX + 1);
  localparam int CAR_W   = $clog2(BLK_W);
  localparam int OCC_W   = $clog2(DEPTH + 1);
  localparam int CHAIN_W = NMAX * BLK_W;

  // Stage 1 outputs
  logic                    s1_v, s1_last;
  logic [LANES*WORD_W-1:0] s1_word;
  logic [LANES*LEN_W-1:0]  s1_len;
  logic [LANES*SUM_W-1:0]  s1_pre;
  logic [SUM_W-1:0]        s1_tot;
  // Stage 2 outputs
  logic                    s2_v, s2_last;
  logic [LANES*WORD_W-1:0] s2_word;
  logic [LANES*LEN_W-1:0]  s2_len;
  logic [LANES*SUM_W-1:0]  s2_pos;
  logic [CNT_W-1:0]        s2_nfull, s2_cnt;
  // Stage 3 outputs
  logic                    s3_last;
  logic [CHAIN_W-1:0]      s3_chain;

  // Named internal events, observed by the bound checker
  logic                    take;
  logic                    q_push;
  logic                    q_full;
  logic [OCC_W-1:0]        q_occ;
  logic [CAR_W-1:0]        carry_len;
  logic [CNT_W-1:0]        push_cnt;

  assign in_ready = (q_occ < OCC_W'(DEPTH - STAGES));
  assign take     = in_valid && in_ready;

  vlp_prefix #(
    .LANES(LANES), .WORD_W(WORD_W), .LEN_W(LEN_W), .SUM_W(SUM_W)
  ) u_prefix (
    .clk(clk), .rst_n(rst_n), .take_i(take),
    .word_i(in_word), .len_i(in_len), .last_i(in_last),
    .v_o(s1_v), .word_o(s1_word), .len_o(s1_len),
    .pre_o(s1_pre), .tot_o(s1_tot), .last_o(s1_last)
  );

  vlp_offset #(
    .LANES(LANES), .WORD_W(WORD_W), .LEN_W(LEN_W), .SUM_W(SUM_W),
    .BLK_W(BLK_W), .CNT_W(CNT_W), .CAR_W(CAR_W)
  ) u_offset (
    .clk(clk), .rst_n(rst_n), .v_i(s1_v),
    .word_i(s1_word), .len_i(s1_len), .pre_i(s1_pre),
    .tot_i(s1_tot), .last_i(s1_last),
    .v_o(s2_v), .word_o(s2_word), .len_o(s2_len), .pos_o(s2_pos),
    .nfull_o(s2_nfull), .cnt_o(s2_cnt), .last_o(s2_last),
    .carry_len_o(carry_len)
  );

  vlp_combine #(
    .LANES(LANES), .WORD_W(WORD_W), .LEN_W(LEN_W), .SUM_W(SUM_W),
    .BLK_W(BLK_W), .NMAX(NMAX), .CNT_W(CNT_W)
  ) u_combine (
    .clk(clk), .rst_n(rst_n), .v_i(s2_v),
    .word_i(s2_word), .len_i(s2_len), .pos_i(s2_pos),
    .nfull_i(s2_nfull), .cnt_i(s2_cnt), .last_i(s2_last),
    .v_o(q_push), .chain_o(s3_chain), .cnt_o(push_cnt), .last_o(s3_last)
  );

  vlp_outq #(
    .BLK_W(BLK_W), .NMAX(NMAX), .CNT_W(CNT_W), .DEPTH(DEPTH), .OCC_W(OCC_W)
  ) u_outq (
    .clk(clk), .rst_n(rst_n), .push_i(q_push),
    .chain_i(s3_chain), .cnt_i(push_cnt), .last_i(s3_last),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_block(out_block), .out_last(out_last),
    .occ_o(q_occ), .full_o(q_full)
  );

endmodule

// File: rtl/vlp_checker.sv
module vlp_checker #(
  parameter int LANES  = 4,
  parameter int WORD_W = 32,
  parameter int BLK_W  = 32,
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 6,
  parameter int NMAX   = 6,
  parameter int CNT_W  = 3,
  parameter int CAR_W  = 5,
  parameter int OCC_W  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [LANES*LEN_W-1:0] in_len,
  input logic                   in_last,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [BLK_W-1:0]       out_block,
  input logic                   out_last,
  input logic                   q_push,
  input logic                   q_full,
  input logic [OCC_W-1:0]       q_occ,
  input logic [CAR_W-1:0]       carry_len,
  input logic [CNT_W-1:0]       push_cnt
);

  // R2: offered lane lengths stay within the word width
  for (genvar g = 0; g < LANES; g++) begin : g_len
    a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (in_len[g*LEN_W +: LEN_W] <= LEN_W'(WORD_W)));
  end

  // R7: a group never arrives at a full FIFO
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> !q_full);

  // R7: occupancy never passes the depth
  a_r7_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_occ <= OCC_W'(DEPTH));

  // R6: a stalled block holds its data
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_block) && $stable(out_last)));

  // R4: a flush clears the pending count once it passes the offset stage
  a_r4_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |-> ##2 (carry_len == '0));

  // R5: every stored group holds between one and NMAX blocks
  a_r5_group_size: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> (push_cnt != '0 && push_cnt <= CNT_W'(NMAX)));

endmodule

bind varlen_packer vlp_checker #(
  .LANES(LANES), .WORD_W(WORD_W), .BLK_W(BLK_W), .DEPTH(DEPTH),
  .LEN_W(LEN_W), .NMAX(NMAX), .CNT_W(CNT_W), .CAR_W(CAR_W), .OCC_W(OCC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_len(in_len), .in_last(in_last), .out_valid(out_valid),
  .out_ready(out_ready), .out_block(out_block), .out_last(out_last),
  .q_push(q_push), .q_full(q_full), .q_occ(q_occ),
  .carry_len(carry_len), .push_cnt(push_cnt)
);

// File: tb/tb_varlen_packer.sv
module tb_varlen_packer;
  localparam int LANES  = 4;
  localparam int WORD_W = 32;
  localparam int BLK_W  = 32;
  localparam int DEPTH  = 8;
  localparam int LEN_W  = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_last;
  logic [LANES*WORD_W-1:0] in_word;
  logic [LANES*LEN_W-1:0]  in_len;
  logic out_valid, out_ready, out_last;
  logic [BLK_W-1:0] out_block;

  always #2 clk = ~clk;

  varlen_packer #(.LANES(LANES), .WORD_W(WORD_W), .BLK_W(BLK_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_len(in_len), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_block(out_block), .out_last(out_last)
  );

  int checks = 0;
  int fails  = 0;
  int accepted = 0;
  string tag = "R8";
  logic [BLK_W-1:0] exp_blk[$];
  bit               exp_lst[$];
  logic [BLK_W-1:0] acc = '0;
  int               nb = 0;
  logic [WORD_W-1:0] cw[LANES];
  int                cl[LANES];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference stream: append the low len bits of each lane, MSB first.
  task automatic model(bit lst);
    int pushed = 0;
    for (int i = 0; i < LANES; i++) begin
      for (int b = cl[i] - 1; b >= 0; b--) begin
        acc[BLK_W-1-nb] = cw[i][b];
        nb++;
        if (nb == BLK_W) begin
          exp_blk.push_back(acc);
          exp_lst.push_back(1'b0);
          acc = '0;
          nb = 0;
          pushed++;
        end
      end
    end
    if (lst) begin
      if (nb > 0) begin
        exp_blk.push_back(acc);
        exp_lst.push_back(1'b1);
      end else if (pushed > 0) begin
        exp_lst[exp_lst.size()-1] = 1'b1;
      end else begin
        exp_blk.push_back('0);
        exp_lst.push_back(1'b1);
      end
      acc = '0;
      nb = 0;
    end
  endtask

  task automatic set_lanes(int l0, int l1, int l2, int l3);
    cl[0] = l0; cl[1] = l1; cl[2] = l2; cl[3] = l3;
    for (int i = 0; i < LANES; i++) cw[i] = $urandom();
  endtask

  task automatic rnd_lanes(int maxlen);
    for (int i = 0; i < LANES; i++) begin
      cw[i] = $urandom();
      cl[i] = $urandom_range(0, maxlen);
    end
  endtask

  // Called at a falling edge: compare the output, drive the next inputs.
  task automatic tick(bit iv, bit lst, bit ordy);
    logic [BLK_W-1:0] eb;
    bit el;
    out_ready = ordy;
    if (out_valid && out_ready) begin
      if (exp_blk.size() == 0) begin
        check(1'b0, tag, "unexpected block", out_block, 0);
      end else begin
        eb = exp_blk.pop_front();
        el = exp_lst.pop_front();
        check(out_block == eb, tag, "block", out_block, eb);
        check(out_last == el, tag, "last flag", out_last, el);
      end
    end
    in_valid = iv;
    in_last  = lst;
    for (int i = 0; i < LANES; i++) begin
      in_word[i*WORD_W +: WORD_W] = cw[i];
      in_len[i*LEN_W +: LEN_W]    = LEN_W'(cl[i]);
    end
    if (iv && in_ready) begin
      accepted++;
      model(lst);
    end
    @(negedge clk);
  endtask

  task automatic drain();
    for (int k = 0; k < 400; k++) begin
      rnd_lanes(32);
      tick(1'b0, ($urandom % 2) == 1, 1'b1);
      if (exp_blk.size() == 0 && !out_valid) break;
    end
    check(exp_blk.size() == 0, tag, "blocks still expected", exp_blk.size(), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [BLK_W-1:0] held;
    logic             held_last;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b0;
    in_word = '0; in_len = '0;
    for (int i = 0; i < LANES; i++) begin cw[i] = '0; cl[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: reset state
    tag = "R8";
    check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
    repeat (2) tick(1'b0, 1'b0, 1'b0);

    // R7: output stalled, full-width words make one group per cycle
    tag = "R7";
    accepted = 0;
    held = '0;
    held_last = 1'b0;
    for (int k = 0; k < 14; k++) begin
      set_lanes(32, 32, 32, 32);
      tick(1'b1, 1'b0, 1'b0);
      if (k == 11) begin held = out_block; held_last = out_last; end
    end
    check(accepted == DEPTH, "R7", "cycles accepted while stalled", accepted, DEPTH);
    check(in_ready == 1'b0, "R7", "in_ready with full FIFO", in_ready, 0);
    // R6: stalled block unchanged
    tag = "R6";
    check(out_valid == 1'b1, "R6", "out_valid while stalled", out_valid, 1);
    check(out_block == held, "R6", "block held while stalled", out_block, held);
    check(out_last == held_last, "R6", "last held while stalled", out_last, held_last);
    tag = "R7";
    drain();
    check(in_ready == 1'b1, "R7", "in_ready after drain", in_ready, 1);

    // R5: flush with nothing pending and no input bits
    tag = "R5";
    set_lanes(0, 0, 0, 0);
    tick(1'b1, 1'b1, 1'b1);
    drain();
    // R5: flush landing exactly on a block boundary
    set_lanes(32, 0, 32, 0);
    tick(1'b1, 1'b1, 1'b1);
    drain();

    // R4: short tail padded with zeros
    tag = "R4";
    set_lanes(5, 0, 3, 0);
    tick(1'b1, 1'b1, 1'b1);
    drain();

    // R2: garbage above the length, zero-length lanes
    tag = "R2";
    for (int k = 0; k < 8; k++) begin
      set_lanes(k % 2 == 0 ? 0 : 1, 31, 0, 3 + k);
      tick(1'b1, 1'b0, 1'b1);
    end
    set_lanes(0, 0, 0, 0);
    tick(1'b1, 1'b1, 1'b1);
    drain();

    // R9: idle cycles carrying junk
    tag = "R9";
    set_lanes(9, 0, 0, 0);
    tick(1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 5; k++) begin
      rnd_lanes(32);
      tick(1'b0, 1'b1, 1'b1);
    end
    set_lanes(0, 30, 0, 0);
    tick(1'b1, 1'b1, 1'b1);
    drain();

    // R3: small words spanning many cycles
    tag = "R3";
    for (int k = 0; k < 12; k++) begin
      set_lanes(7, 7, 7, 7);
      tick(1'b1, 1'b0, 1'b1);
    end
    set_lanes(1, 0, 0, 0);
    tick(1'b1, 1'b1, 1'b1);
    drain();

    // R1: random lengths, random flushes, random output stalls
    tag = "R1";
    for (int k = 0; k < 3000; k++) begin
      rnd_lanes(32);
      tick(($urandom % 5) != 0, ($urandom % 40) == 0, ($urandom % 10) < 7);
    end
    set_lanes(0, 0, 0, 0);
    for (int k = 0; k < 40; k++) begin
      if (in_ready) begin
        tick(1'b1, 1'b1, 1'b1);
        break;
      end
      tick(1'b0, 1'b0, 1'b1);
    end
    drain();
    check(in_ready == 1'b1, "R1", "in_ready at end", in_ready, 1);

    summary();
    $finish;
  end

endmodule